// File: doc/BRIEF.md
# AGC Loop Filter Accumulator

This block is the loop filter of a receiver's automatic gain control. On every cycle where the magnitude strobe is high, it compares a precomputed unsigned signal magnitude with a programmable threshold. A magnitude below the threshold raises a gain accumulator by a programmable step. A magnitude at or above the threshold lowers it by the same step. The result is then pinned between a programmable floor and a programmable ceiling before it is stored.

The gain is presented as a 3-bit exponent and a 5-bit mantissa, taken from the top byte of a 16-bit accumulator. That accumulator has 3 integer bits and 13 fraction bits. All four settings are held in one 32-bit control word, written over a plain write-enable/data pair. Rewriting that word never disturbs the stored gain.

Top module: `agc_loop_filter`

## Requirements
- R1: While reset is asserted and after it is released, the gain output equals the floor field of the reset control word, with the accumulator fraction cleared. With the default word 32'h1020_E080 this is 8'h20. The gain byte is {gain_exp, gain_man}, with the exponent in its top 3 bits.
- R2: On a strobed cycle where the magnitude is below the threshold, the accumulator grows by the step field. The step LSB adds at accumulator bit 0 (weight 2^-13) and its MSB at bit 7 (weight 2^-6). The gain byte is accumulator bits 15:8.
- R3: On a strobed cycle where the magnitude is equal to or greater than the threshold, the accumulator shrinks by the step field, with the same alignment as in R2.
- R4: On a cycle where the strobe is low, the accumulator and gain keep their value.
- R5: When an increase carries out of the 16-bit accumulator, or leaves its top byte above the ceiling, the accumulator becomes {ceiling, 8'h00} in that same update.
- R6: When a decrease borrows below zero, the accumulator becomes {floor, 8'h00}. When a result has no carry or borrow, a top byte that is not above the ceiling but is below the floor also gives {floor, 8'h00}.
- R7: Control word fields: threshold in bits 7:0 (1 integer bit, 7 fraction bits), ceiling in bits 15:8, floor in bits 23:16, step in bits 31:24.
- R8: A control write takes effect for strobed samples after the clock edge that captures it. A sample strobed in the same cycle as the write uses the previous word. A write never changes the gain on its own.
- R9: If the threshold exceeds every magnitude that arrives, the gain climbs on each sample and settles at the ceiling.
- R10: If the ceiling is set below the floor, a result that needs no carry or borrow clamp and lies above the ceiling takes the ceiling. After any strobed update the gain is therefore either the ceiling or the floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word value |
| mag_valid | input | 1 | Magnitude sample strobe |
| mag_in | input | 8 | Unsigned magnitude, 1 integer and 7 fraction bits |
| gain_exp | output | 3 | Gain exponent |
| gain_man | output | 5 | Gain mantissa |

## Verification
The bench drives the accumulator into a carry out of 16 bits and into a borrow below zero. A design that lets either wrap would show a gain near the opposite limit instead of the clamp value. Magnitudes exactly equal to the threshold are sent to expose a comparator that counts equality as "below", which would move the gain the wrong way. Writes that coincide with a strobed sample catch a design that applies the new word one cycle early, and idle writes catch a design that resets the gain on a write. An inverted ceiling/floor pair catches a design whose clamp order differs, and a long random run covers mixed settings.

// File: rtl/agc_lf_pkg.sv
package agc_lf_pkg;

   typedef enum logic {
      AGC_STEP_UP   = 1'b0,
      AGC_STEP_DOWN = 1'b1
   } agc_dir_e;

   typedef enum logic [1:0] {
      CLAMP_NONE = 2'd0,
      CLAMP_HI   = 2'd1,
      CLAMP_LO   = 2'd2
   } agc_clamp_e;

endpackage

// File: rtl/agc_lf_cfg.sv
module agc_lf_cfg #(
   parameter int          MAG_W   = 8,
   parameter int          LIM_W   = 8,
   parameter int          LG_W    = 8,
   parameter int          CFG_W   = MAG_W + 2*LIM_W + LG_W,
   parameter logic [CFG_W-1:0] CFG_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [MAG_W-1:0] thr,
   output logic [LIM_W-1:0] lim_hi,
   output logic [LIM_W-1:0] lim_lo,
   output logic [LG_W-1:0]  step
);
   localparam int HI_LSB = MAG_W;
   localparam int LO_LSB = MAG_W + LIM_W;
   localparam int LG_LSB = MAG_W + 2*LIM_W;

   logic [CFG_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= CFG_RST;
      else if (wr_en) word_q <= wr_data;
   end

   assign thr    = word_q[MAG_W-1:0];
   assign lim_hi = word_q[HI_LSB +: LIM_W];
   assign lim_lo = word_q[LO_LSB +: LIM_W];
   assign step   = word_q[LG_LSB +: LG_W];
endmodule

// File: rtl/agc_lf_cmp.sv
module agc_lf_cmp
   import agc_lf_pkg::*;
#(
   parameter int MAG_W = 8
) (
   input  logic [MAG_W-1:0] mag,
   input  logic [MAG_W-1:0] thr,
   output agc_dir_e         dir
);
   assign dir = (mag < thr) ? AGC_STEP_UP : AGC_STEP_DOWN;
endmodule

// File: rtl/agc_lf_acc.sv
module agc_lf_acc
   import agc_lf_pkg::*;
#(
   parameter int             ACC_W  = 16,
   parameter int             LIM_W  = 8,
   parameter int             LG_W   = 8,
   parameter int             LG_LSB = 0,
   parameter logic [LIM_W-1:0] RST_LO = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  agc_dir_e         dir,
   input  logic [LG_W-1:0]  step,
   input  logic [LIM_W-1:0] lim_hi,
   input  logic [LIM_W-1:0] lim_lo,
   output logic [ACC_W-1:0] acc_q
);
   localparam int FRAC_W = ACC_W - LIM_W;

   logic [ACC_W-1:0] step_ext;
   logic [ACC_W:0]   raw;
   logic             wrap;
   logic [LIM_W-1:0] top;
   agc_clamp_e       clamp;
   logic [ACC_W-1:0] nxt;

   generate
      if (LG_LSB == 0) begin : g_step_lsb0
         assign step_ext = ACC_W'(step);
      end else begin : g_step_shift
         assign step_ext = ACC_W'({step, {LG_LSB{1'b0}}});
      end
   endgenerate

   assign raw  = (dir == AGC_STEP_UP) ? ({1'b0, acc_q} + {1'b0, step_ext})
                                      : ({1'b0, acc_q} - {1'b0, step_ext});
   assign wrap = raw[ACC_W];
   assign top  = raw[ACC_W-1 -: LIM_W];

   always_comb begin
      if (wrap)
         clamp = (dir == AGC_STEP_UP) ? CLAMP_HI : CLAMP_LO;
      else if (top > lim_hi)
         clamp = CLAMP_HI;
      else if (top < lim_lo)
         clamp = CLAMP_LO;
      else
         clamp = CLAMP_NONE;
   end

   always_comb begin
      unique case (clamp)
         CLAMP_HI: nxt = {lim_hi, {FRAC_W{1'b0}}};
         CLAMP_LO: nxt = {lim_lo, {FRAC_W{1'b0}}};
         default:  nxt = raw[ACC_W-1:0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= {RST_LO, {FRAC_W{1'b0}}};
      else if (step_en) acc_q <= nxt;
   end
endmodule

// File: rtl/agc_loop_filter.sv
module agc_loop_filter
   import agc_lf_pkg::*;
#(
   parameter int MAG_W  = 8,
   parameter int LIM_W  = 8,
   parameter int EXP_W  = 3,
   parameter int LG_W   = 8,
   parameter int ACC_W  = 16,
   parameter int LG_LSB = 0,
   parameter logic [MAG_W+2*LIM_W+LG_W-1:0] CFG_RST = 32'h1020_E080
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr_en,
   input  logic [MAG_W+2*LIM_W+LG_W-1:0] cfg_wr_data,
   input  logic                     mag_valid,
   input  logic [MAG_W-1:0]         mag_in,
   output logic [EXP_W-1:0]         gain_exp,
   output logic [LIM_W-EXP_W-1:0]   gain_man
);
   localparam int CFG_W  = MAG_W + 2*LIM_W + LG_W;
   localparam int MAN_W  = LIM_W - EXP_W;
   localparam logic [LIM_W-1:0] RST_LO = CFG_RST[MAG_W+LIM_W +: LIM_W];

   generate
      if (ACC_W <= LIM_W) begin : g_bad_acc
         $error("agc_loop_filter: ACC_W must exceed LIM_W");
      end
      if (LG_LSB + LG_W > ACC_W) begin : g_bad_step
         $error("agc_loop_filter: step field does not fit the accumulator");
      end
      if (EXP_W < 1 || EXP_W >= LIM_W) begin : g_bad_exp
         $error("agc_loop_filter: EXP_W out of range");
      end
   endgenerate

   logic [MAG_W-1:0] cfg_thr;
   logic [LIM_W-1:0] cfg_hi;
   logic [LIM_W-1:0] cfg_lo;
   logic [LG_W-1:0]  cfg_step;
   agc_dir_e         dir;
   logic [ACC_W-1:0] acc;
   logic [LIM_W-1:0] gain_word;

   agc_lf_cfg #(
      .MAG_W(MAG_W), .LIM_W(LIM_W), .LG_W(LG_W), .CFG_W(CFG_W), .CFG_RST(CFG_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
      .thr(cfg_thr), .lim_hi(cfg_hi), .lim_lo(cfg_lo), .step(cfg_step)
   );

   agc_lf_cmp #(.MAG_W(MAG_W)) u_cmp (
      .mag(mag_in), .thr(cfg_thr), .dir(dir)
   );

   agc_lf_acc #(
      .ACC_W(ACC_W), .LIM_W(LIM_W), .LG_W(LG_W), .LG_LSB(LG_LSB), .RST_LO(RST_LO)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .step_en(mag_valid), .dir(dir), .step(cfg_step),
      .lim_hi(cfg_hi), .lim_lo(cfg_lo), .acc_q(acc)
   );

   assign gain_word = acc[ACC_W-1 -: LIM_W];
   assign gain_exp  = gain_word[LIM_W-1 -: EXP_W];
   assign gain_man  = gain_word[MAN_W-1:0];
endmodule

// File: rtl/agc_lf_chk.sv
module agc_lf_chk #(
   parameter int MAG_W = 8,
   parameter int LIM_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mag_valid,
   input logic [MAG_W-1:0] mag_in,
   input logic [MAG_W-1:0] thr,
   input logic [LIM_W-1:0] hi,
   input logic [LIM_W-1:0] lo,
   input logic [LIM_W-1:0] gain
);
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mag_valid |=> $stable(gain)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_valid && hi >= lo) |=> gain <= $past(hi)); // R5

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_valid && hi >= lo) |=> gain >= $past(lo)); // R6

   AST_RISE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_valid && mag_in < thr && gain <= hi && hi >= lo) |=> gain >= $past(gain)); // R2

   AST_FALL_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_valid && mag_in >= thr && gain >= lo && hi >= lo) |=> gain <= $past(gain)); // R3

   AST_INVERTED_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_valid && hi < lo) |=> (gain == $past(hi) || gain == $past(lo))); // R10
endmodule

bind agc_loop_filter agc_lf_chk #(.MAG_W(MAG_W), .LIM_W(LIM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mag_valid(mag_valid), .mag_in(mag_in),
   .thr(cfg_thr), .hi(cfg_hi), .lo(cfg_lo), .gain(gain_word)
);

// File: tb/agc_loop_filter_tb_top.sv
`timescale 1ns/1ps
module agc_loop_filter_tb_top;
   localparam logic [31:0] RST_WORD = 32'h1020_E080;

   typedef struct {
      logic [7:0] gain;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic        mag_valid = 1'b0;
   logic [7:0]  mag_in = '0;
   logic [2:0]  gain_exp;
   logic [4:0]  gain_man;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 0;
   exp_t exp_q[$];

   logic [15:0] m_acc;
   logic [31:0] m_cfg;

   always #2.5 clk = ~clk;

   agc_loop_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .mag_valid(mag_valid), .mag_in(mag_in), .gain_exp(gain_exp), .gain_man(gain_man)
   );

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   // driver: applies one cycle of stimulus and queues the expected gain
   task automatic step(input logic v, input logic [7:0] m, input logic w,
                       input logic [31:0] d, input string tag);
      exp_t        e;
      logic [16:0] s;
      logic        inc;
      logic [7:0]  hi, lo;
      string       t;
      @(negedge clk);
      mag_valid = v; mag_in = m; cfg_wr_en = w; cfg_wr_data = d;
      t = "R4";
      if (v) begin
         hi  = m_cfg[15:8];
         lo  = m_cfg[23:16];
         inc = (m < m_cfg[7:0]);
         s   = inc ? ({1'b0, m_acc} + {9'd0, m_cfg[31:24]})
                   : ({1'b0, m_acc} - {9'd0, m_cfg[31:24]});
         t   = inc ? "R2" : "R3";
         if (s[16] && inc)            begin m_acc = {hi, 8'h00}; t = "R5"; end
         else if (s[16])              begin m_acc = {lo, 8'h00}; t = "R6"; end
         else if (s[15:8] > hi)       begin m_acc = {hi, 8'h00}; t = "R5"; end
         else if (s[15:8] < lo)       begin m_acc = {lo, 8'h00}; t = "R6"; end
         else                         m_acc = s[15:0];
      end
      if (w) m_cfg = d;
      e.gain = m_acc[15:8];
      e.tag  = (tag == "") ? t : tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares design output with the scoreboard after each edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if ({gain_exp, gain_man} !== e.gain) begin
               n_bad++;
               $display("FAIL %s: gain actual=%h expected=%h", e.tag,
                        {gain_exp, gain_man}, e.gain);
            end
         end
      end
   end

   initial begin
      #(5.0 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      m_cfg = RST_WORD;
      m_acc = {RST_WORD[23:16], 8'h00};
      repeat (3) @(negedge clk);
      n_chk++;   // R1 during reset
      if ({gain_exp, gain_man} !== 8'h20) begin
         n_bad++;
         $display("FAIL R1: gain actual=%h expected=20", {gain_exp, gain_man});
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;   // R1 after release
      if ({gain_exp, gain_man} !== 8'h20) begin
         n_bad++;
         $display("FAIL R1: gain actual=%h expected=20", {gain_exp, gain_man});
      end

      repeat (3) step(0, 8'h00, 0, 0, "R4");
      repeat (20) step(1, 8'h10, 0, 0, "R2");       // below threshold 0x80
      repeat (6) step(1, 8'h80, 0, 0, "R3");        // equal to threshold
      repeat (3) step(1, 8'hC0, 0, 0, "R3");
      // R7: new step/threshold fields, then climb to ceiling (R9)
      step(0, 8'h00, 1, 32'hFF20_E0FF, "R8");
      repeat (40) step(1, 8'hFE, 0, 0, "R9");
      // R7: floor field 0x40, threshold 0 forces descent to floor
      step(0, 8'h00, 1, 32'hFF40_E000, "R7");
      repeat (40) step(1, 8'h00, 0, 0, "R6");
      // carry out of the accumulator with ceiling 0xFF
      step(0, 8'h00, 1, 32'hFF00_FFFF, "R7");
      repeat (300) step(1, 8'h10, 0, 0, "R5");
      // borrow below zero with floor 0
      step(0, 8'h00, 1, 32'hFF00_FF00, "R7");
      repeat (300) step(1, 8'h10, 0, 0, "R6");
      // write coinciding with a strobed sample uses the old word
      step(1, 8'h10, 1, 32'h0800_FFFF, "R8");
      step(1, 8'h10, 0, 0, "R8");
      step(0, 8'h10, 1, 32'h0100_FF80, "R8");
      step(1, 8'h10, 0, 0, "R8");
      // ceiling below floor
      step(0, 8'h00, 1, 32'h4050_3080, "R10");
      repeat (10) step(1, 8'h10, 0, 0, "R10");
      repeat (10) step(1, 8'hF0, 0, 0, "R10");
      // mixed random traffic
      for (int i = 0; i < 600; i++) begin
         logic [31:0] w;
         logic [7:0]  lo_r, hi_r;
         lo_r = 8'($urandom_range(0, 120));
         hi_r = 8'($urandom_range(130, 255));
         w = {8'($urandom), lo_r, hi_r, 8'($urandom)};
         step(1'($urandom), 8'($urandom), ($urandom_range(0, 15) == 0), w, "");
      end
      step(0, 8'h00, 0, 0, "R4");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      finish_run();
   end
endmodule